// File: doc/BRIEF.md
# PLL Bus-Clock Select Controller

This block holds the byte-wide control register of an on-chip frequency synthesizer and uses it to switch the internal bus clock between two sources without glitches. The two sources are the clock from the crystal oscillator and the synthesizer output. A CPU reads and writes the register through a simple single-cycle bus port that runs on the crystal clock. The register drives four things: the synthesizer enable, the high-bandwidth loop driver, a VCO test strobe and a two-bit multiplier select.

The select bit picks the bus clock source. When it changes, a clock switch with cross-coupled enables first turns the old source off on that source's falling edge. It then turns the new source on, on the new source's falling edge. Between the two, the bus clock stays low and a stall output stops CPU and timer logic. Hardware enforces one interlock: the select bit can only be set once the synthesizer enable is already on. Lock-time delays are left to software.

Top module: `pll_clock_ctrl`

## Requirements
- R1: The register is decoded at address REG_ADDR (default 0x07). A read at that address returns the register. A read at any other address returns 0x00, and a write to any other address changes nothing.
- R2: Bit positions: 7 = source select, 5 = high-bandwidth enable, 4 = synthesizer enable, 3 = VCO test, 1:0 = multiplier select. Bits 6 and 2 always read 0, and writes to them are ignored.
- R3: A write with bit 7 = 1 sets the select bit only if bit 4 of the register was already 1 before that write. If a single write sets both bits starting from bit 4 = 0, the select bit stays 0.
- R4: A write that clears bit 4 also clears the select bit. This starts a switch back to the crystal source.
- R5: After reset, the register reads 0x00 | PS_RESET (0x01 by default), stall is 0 and the bus clock follows the crystal clock.
- R6: The high-bandwidth enable output equals bit 5. The low-bandwidth enable output is always 1. Bit 5 = 1 does not prevent setting the select bit.
- R7: Once a switch has settled, the bus clock follows the crystal clock when select = 0 and the synthesizer clock when select = 1.
- R8: The two source enables are never on together. The bus clock never produces a high or low pulse shorter than the shorter half-period of the two sources.
- R9: Stall rises in the first crystal cycle after the select bit changes and falls when the new source is enabled. This happens no later than (SYNC_STAGES+1) x (crystal period + synthesizer period) after the write.
- R10: The synthesizer enable, VCO test and multiplier select outputs mirror bits 4, 3 and 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Crystal-derived clock; also clocks the register |
| pll_clk | input | 1 | Synthesizer output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, sampled on osc_clk rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pll_en | output | 1 | Synthesizer enable |
| hibw_en | output | 1 | High-bandwidth loop driver enable |
| lobw_en | output | 1 | Low-bandwidth loop driver enable (always on) |
| vco_test | output | 1 | VCO test bit |
| freq_sel | output | 2 | Multiplier select |
| bus_clk | output | 1 | Switched internal bus clock |
| stall | output | 1 | Holds CPU and timer logic during a switch |

## Verification
The bench builds the block with its default parameters: an 8-bit address, the register at 0x07, a two-flop synchronizer and a reset multiplier code of 01. The sources are a 5 ns crystal clock and a 7 ns synthesizer clock, so the switch delay depends on the ratio of the two periods. With these values, switches in both directions come within reach, and the bench can measure the stall window against its two-stage bound. It can also measure the shortest pulse on the bus clock against the 2.5 ns half-period of the crystal clock.

// File: rtl/pllsel_pkg.sv
// Shared bit positions and the register view for the clock-select controller.
package pllsel_pkg;
    localparam int DATA_W  = 8;
    localparam int BIT_SEL = 7;
    localparam int BIT_BW  = 5;
    localparam int BIT_ON  = 4;
    localparam int BIT_VT  = 3;

    typedef struct packed {
        logic       sel;   // bus clock source: 1 = synthesizer
        logic       bw;    // high-bandwidth driver on
        logic       on;    // synthesizer enabled
        logic       vt;    // VCO test
        logic [1:0] ps;    // multiplier select
    } pll_ctrl_t;
endpackage

// File: rtl/pllsel_sync.sv
// Multi-stage synchronizer for one bit.
// Assumes: d may change asynchronously to clk; reset is synchronous, active low.
module pllsel_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pllsel_regs.sv
// Control register with a bus port and the select interlock.
// Assumes: the bus runs on clk (the crystal clock); reads are combinational.
module pllsel_regs
    import pllsel_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         REG_ADDR = 7,
    parameter logic [1:0] PS_RESET = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output pll_ctrl_t         ctrl
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

    logic hit;
    logic sel_next;

    assign hit = (addr == MY_ADDR);
    // select needs the enable already on, and is dropped when the enable is cleared
    assign sel_next = wdata[BIT_SEL] & ctrl.on & wdata[BIT_ON];

    // register update on a decoded write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '{sel: 1'b0, bw: 1'b0, on: 1'b0, vt: 1'b0, ps: PS_RESET};
        end else if (wr && hit) begin
            ctrl.sel <= sel_next;
            ctrl.bw  <= wdata[BIT_BW];
            ctrl.on  <= wdata[BIT_ON];
            ctrl.vt  <= wdata[BIT_VT];
            ctrl.ps  <= wdata[1:0];
        end
    end

    // read mux: unimplemented bits return zero
    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[BIT_SEL] = ctrl.sel;
            rdata[BIT_BW]  = ctrl.bw;
            rdata[BIT_ON]  = ctrl.on;
            rdata[BIT_VT]  = ctrl.vt;
            rdata[1:0]     = ctrl.ps;
        end
    end
endmodule

// File: rtl/pllsel_clkswitch.sv
// Glitch-free two-source clock switch with cross-coupled enables.
// Each side synchronizes its request on its own rising edge and changes its
// enable on its own falling edge, so the output never cuts a high phase short.
// Assumes: sel is stable in the osc_clk domain; both clocks run during reset.
module pllsel_clkswitch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic pll_clk,
    input  logic rst_n,
    input  logic sel,
    output logic bus_clk,
    output logic stall,
    output logic en_osc,
    output logic en_pll
);
    logic osc_req, osc_sync;
    logic pll_req, pll_sync;

    assign osc_req = ~sel & ~en_pll;
    assign pll_req =  sel & ~en_osc;

    pllsel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_osc (
        .clk(osc_clk), .rst_n(rst_n), .d(osc_req), .q(osc_sync)
    );

    pllsel_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pll (
        .clk(pll_clk), .rst_n(rst_n), .d(pll_req), .q(pll_sync)
    );

    // crystal-side enable changes while the crystal clock is low
    always_ff @(negedge osc_clk) begin
        if (!rst_n) en_osc <= 1'b1;
        else        en_osc <= osc_sync;
    end

    // synthesizer-side enable changes while the synthesizer clock is low
    always_ff @(negedge pll_clk) begin
        if (!rst_n) en_pll <= 1'b0;
        else        en_pll <= pll_sync;
    end

    assign bus_clk = (osc_clk & en_osc) | (pll_clk & en_pll);
    assign stall   = sel ? ~en_pll : ~en_osc;
endmodule

// File: rtl/pll_clock_ctrl.sv
// Top: control register plus glitch-free bus clock switch.
// Assumes: the CPU bus is clocked by the crystal clock, which always runs.
module pll_clock_ctrl
    import pllsel_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         REG_ADDR    = 7,
    parameter logic [1:0] PS_RESET    = 2'b01,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              osc_clk,
    input  logic              pll_clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              pll_en,
    output logic              hibw_en,
    output logic              lobw_en,
    output logic              vco_test,
    output logic [1:0]        freq_sel,
    output logic              bus_clk,
    output logic              stall
);
    pll_ctrl_t ctrl;
    logic      en_osc, en_pll;

    pllsel_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .PS_RESET(PS_RESET)) u_regs (
        .clk(osc_clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
        .wdata(bus_wdata), .rdata(bus_rdata), .ctrl(ctrl)
    );

    pllsel_clkswitch #(.SYNC_STAGES(SYNC_STAGES)) u_switch (
        .osc_clk(osc_clk), .pll_clk(pll_clk), .rst_n(rst_n), .sel(ctrl.sel),
        .bus_clk(bus_clk), .stall(stall), .en_osc(en_osc), .en_pll(en_pll)
    );

    assign pll_en   = ctrl.on;
    assign hibw_en  = ctrl.bw;
    assign lobw_en  = 1'b1;
    assign vco_test = ctrl.vt;
    assign freq_sel = ctrl.ps;
endmodule

// File: rtl/pllsel_checker.sv
// Protocol checks for pll_clock_ctrl, attached by bind.
module pllsel_checker (
    input logic       osc_clk,
    input logic       rst_n,
    input logic       sel,
    input logic       pll_en,
    input logic       hibw_en,
    input logic       en_osc,
    input logic       en_pll,
    input logic       stall,
    input logic [7:0] rdata
);
    AST_SEL_NEEDS_ENABLE: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(sel) |-> $past(pll_en)); // R3

    AST_SEL_IMPLIES_ENABLE: assert property (@(posedge osc_clk) disable iff (!rst_n)
        sel |-> pll_en); // R4

    AST_RESET_CLEARS: assert property (@(posedge osc_clk)
        !rst_n |=> (!sel && !hibw_en && !pll_en)); // R5

    AST_ONE_SOURCE: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !(en_osc && en_pll)); // R8

    AST_CHANGE_STALLS: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (!$past(stall) && (sel != $past(sel))) |-> stall); // R9

    AST_GAP_BITS_ZERO: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (rdata[6] == 1'b0) && (rdata[2] == 1'b0)); // R2
endmodule

bind pll_clock_ctrl pllsel_checker u_chk (
    .osc_clk(osc_clk), .rst_n(rst_n), .sel(ctrl.sel), .pll_en(pll_en),
    .hibw_en(hibw_en), .en_osc(en_osc), .en_pll(en_pll), .stall(stall),
    .rdata(bus_rdata)
);

// File: tb/pll_clock_ctrl_bench.sv
module pll_clock_ctrl_bench;
    localparam realtime TOSC = 5.0;
    localparam realtime TPLL = 7.0;
    localparam int      SYNC = 2;
    localparam realtime SW_BOUND = (SYNC + 1) * (TOSC + TPLL);

    logic       osc_clk = 0, pll_clk = 0, rst_n = 0;
    logic [7:0] bus_addr = 8'h07, bus_wdata = 8'h00;
    logic       bus_wr = 0;
    logic [7:0] bus_rdata;
    logic       pll_en, hibw_en, lobw_en, vco_test, bus_clk, stall;
    logic [1:0] freq_sel;

    int checks = 0, fails = 0;
    bit done = 0;

    always #(TOSC/2) osc_clk = ~osc_clk;
    always #(TPLL/2) pll_clk = ~pll_clk;

    pll_clock_ctrl u_pll_clock_ctrl (
        .osc_clk(osc_clk), .pll_clk(pll_clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pll_en(pll_en), .hibw_en(hibw_en), .lobw_en(lobw_en), .vco_test(vco_test),
        .freq_sel(freq_sel), .bus_clk(bus_clk), .stall(stall)
    );

    // pulse-width monitor for R8
    bit      armed = 0;
    realtime last_edge = 0, min_pulse = 1000.0;
    always @(bus_clk) begin
        if (armed) begin
            if ($realtime - last_edge < min_pulse) min_pulse = $realtime - last_edge;
        end
        last_edge = $realtime;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write(input logic [7:0] a, input logic [7:0] d);
        @(negedge osc_clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge osc_clk);
        bus_wr = 0; bus_addr = 8'h07;
    endtask

    task automatic settle();
        repeat (40) @(negedge osc_clk);
    endtask

    // R7: bus clock tracks the chosen source in both phases
    task automatic check_follow(input bit use_pll, input string req);
        if (use_pll) begin
            @(posedge pll_clk); #1; check(bus_clk == 1, req, bus_clk, 1);
            @(negedge pll_clk); #1; check(bus_clk == 0, req, bus_clk, 0);
        end else begin
            @(posedge osc_clk); #1; check(bus_clk == 1, req, bus_clk, 1);
            @(negedge osc_clk); #1; check(bus_clk == 0, req, bus_clk, 0);
        end
    endtask

    // measure the switch window after a write that flips the select bit (R9)
    task automatic timed_switch(input logic [7:0] d, input bit to_pll);
        realtime t0;
        @(negedge osc_clk);
        bus_wdata = d; bus_wr = 1;
        @(posedge osc_clk); t0 = $realtime;
        #1; check(stall == 1, "R9 stall raised", stall, 1);
        @(negedge osc_clk); bus_wr = 0;
        while (stall && ($realtime - t0 < 200.0)) #0.5;
        check(($realtime - t0) <= SW_BOUND, "R9 window", int'($realtime - t0), int'(SW_BOUND));
        settle();
        check_follow(to_pll, "R7 after timed switch");
    endtask

    // vectors: {write data, expected readback}
    localparam logic [15:0] VEC [8] = '{
        {8'h10, 8'h10},   // enable only
        {8'h90, 8'h90},   // R3 select accepted
        {8'h00, 8'h00},   // R4 drop both
        {8'h90, 8'h10},   // R3 refused in same write
        {8'hFF, 8'hBB},   // R2 gap bits dropped, select accepted
        {8'h20, 8'h20},   // R4 clears select, R6 bandwidth
        {8'h30, 8'h30},
        {8'hB0, 8'hB0}    // R6 bandwidth does not block select
    };

    initial begin
        repeat (10) @(negedge osc_clk);
        rst_n = 1;
        @(negedge osc_clk); #1;
        // R5 reset state
        check(bus_rdata == 8'h01, "R5 reset readback", bus_rdata, 8'h01);
        check(stall == 0, "R5 stall", stall, 0);
        check(pll_en == 0 && hibw_en == 0, "R5 enables", {pll_en, hibw_en}, 0);
        check_follow(0, "R5 crystal after reset");
        armed = 1;

        foreach (VEC[i]) begin
            write(8'h07, VEC[i][15:8]);
            settle(); #1;
            check(bus_rdata == VEC[i][7:0], "R1 R3 R4 readback", bus_rdata, VEC[i][7:0]);
            check(stall == 0, "R9 settled", stall, 0);
            check(hibw_en == VEC[i][5] && lobw_en == 1, "R6 drivers",
                  {hibw_en, lobw_en}, {VEC[i][5], 1'b1});
            check(pll_en == VEC[i][4] && vco_test == VEC[i][3] && freq_sel == VEC[i][1:0],
                  "R10 outputs", {pll_en, vco_test, freq_sel}, {VEC[i][4], VEC[i][3], VEC[i][1:0]});
            check_follow(VEC[i][7], "R7 source");
        end

        // R1: other address reads zero, writes there are ignored
        write(8'h06, 8'h00);
        @(negedge osc_clk); bus_addr = 8'h06; #1;
        check(bus_rdata == 8'h00, "R1 other address read", bus_rdata, 0);
        bus_addr = 8'h07; #1;
        check(bus_rdata == 8'hB0, "R1 other address write ignored", bus_rdata, 8'hB0);

        // R9: timed switches in both directions
        write(8'h07, 8'h10); settle();
        timed_switch(8'h90, 1);
        timed_switch(8'h10, 0);

        // R8: no runt pulse anywhere on the bus clock
        check(min_pulse >= TOSC/2 - 0.01, "R8 min pulse", int'(min_pulse * 100), int'(TOSC * 50));
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                #100000;
                checks++; fails++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule